// File: doc/BRIEF.md
# Block-Storage Controller Register Front End

This block is the register bank that a processor uses to set up a block-storage transfer. Software selects a disk, names a starting block, gives a transfer length in blocks and a DMA target address, then writes a command. Every write is checked against the capacity of the selected disk, which is fixed per disk by a parameter. The result of the most recent checked access is held in a status register that software can read back. Reading the size slot returns the selected disk's capacity in bytes.

Access is through a simple request bus. A request is accepted in every cycle where `req_valid` is high, so there is no back-pressure and no ready signal. Each accepted read produces exactly one response, with `rsp_valid` high, in the following cycle. Writes produce no response. The register slots sit 8 bytes apart. The slot number is `req_addr >> 3`, and the three low address bits are ignored.

The programmed values drive a transfer engine, which is not part of this block, over plain output pins. That engine receives a one-cycle `cmd_start` strobe whenever the command slot is written.

Top module: `disk_ctrl_regs`

## Requirements
- R1: After reset, `disk_sel`, `cur_block`, `xfer_count`, `dma_addr`, `cmd_value`, `cmd_start` and `rsp_valid` are 0, and `status_code` is 0 (OK).
- R2: An accepted read raises `rsp_valid` for one cycle in the next cycle, with `rsp_rdata` holding the slot's value. Slot 0 is the disk index, slot 1 the current block, slot 3 the DMA address, slot 4 the command and slot 5 the status, all zero-extended. Address bits [2:0] are ignored. Writes never raise `rsp_valid`.
- R3: A write to slot 0 with a value below NUM_DISKS selects that disk and sets status to 0 (OK). Any other value leaves the selection unchanged and sets status to 1 (bad disk).
- R4: A write to slot 1 with a value below the selected disk's block count updates the current block and leaves status unchanged. Any other value leaves the block unchanged and sets status to 2 (bad block).
- R5: A write to slot 2 sets the transfer count to the written value, or to the selected disk's block count minus one when the value is at least that count, and sets status to 0.
- R6: A write to slot 3 stores the DMA address and sets status to 0.
- R7: A read of slot 2 returns the selected disk's block count times BLOCK_BYTES.
- R8: A write to slot 4 latches the command and raises `cmd_start` for exactly the next cycle. `cmd_is_write` is 1 when the latched command is nonzero. Status is unchanged.
- R9: A read of any slot above 5 returns 0 and sets status to 3 (bad offset). A write to any slot above 5, or to slot 5, changes no register.
- R10: A read of slots 0 to 5 changes no register and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; slot = addr >> 3 |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| disk_sel | output | SEL_W | Selected disk index |
| cur_block | output | DATA_W | Current block number |
| xfer_count | output | DATA_W | Transfer length in blocks |
| dma_addr | output | DATA_W | DMA physical address |
| cmd_value | output | DATA_W | Latched command |
| cmd_is_write | output | 1 | Latched command is nonzero |
| cmd_start | output | 1 | One-cycle strobe after a command write |
| status_code | output | 2 | Outcome of the last checked access |

## Verification
The assertions assume that at most one request arrives per cycle. They also assume that `req_write`, `req_addr` and `req_wdata` are meaningful only while `req_valid` is high, and that the parameters give every disk a nonzero block count. The bench respects both assumptions. It changes request signals only on the falling edge, and it raises `req_valid` for single-cycle requests, plus one deliberate pair of back-to-back reads. It also keeps the default capacities: disks of 8, 20 and 64 blocks with 512-byte blocks.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_BAD_DISK   = 2'd1,
    ST_BAD_BLOCK  = 2'd2,
    ST_BAD_OFFSET = 2'd3
  } dkc_status_e;

  localparam int SLOT_SEL   = 0;
  localparam int SLOT_BLOCK = 1;
  localparam int SLOT_SIZE  = 2;
  localparam int SLOT_PHYS  = 3;
  localparam int SLOT_CMD   = 4;
  localparam int SLOT_STAT  = 5;
  localparam int SLOT_SHIFT = 3;

  typedef struct packed {
    logic sel;
    logic blk;
    logic size;
    logic phys;
    logic cmd;
    logic stat;
    logic none;
  } dkc_hit_t;

endpackage

// File: rtl/dkc_addr_decode.sv
module dkc_addr_decode
  import dkc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dkc_hit_t          hit
);
  localparam int OFF_W = ADDR_W - SLOT_SHIFT;

  logic [OFF_W-1:0] slot;
  logic             unused_low;

  assign slot       = addr[ADDR_W-1:SLOT_SHIFT];
  assign unused_low = ^addr[SLOT_SHIFT-1:0];

  always_comb begin
    hit      = '0;
    hit.sel  = (slot == OFF_W'(SLOT_SEL));
    hit.blk  = (slot == OFF_W'(SLOT_BLOCK));
    hit.size = (slot == OFF_W'(SLOT_SIZE));
    hit.phys = (slot == OFF_W'(SLOT_PHYS));
    hit.cmd  = (slot == OFF_W'(SLOT_CMD));
    hit.stat = (slot == OFF_W'(SLOT_STAT));
    hit.none = (slot > OFF_W'(SLOT_STAT));
  end
endmodule

// File: rtl/dkc_capacity.sv
module dkc_capacity #(
  parameter int                          NUM_DISKS   = 3,
  parameter int                          CAP_W       = 32,
  parameter int                          DATA_W      = 32,
  parameter int                          SEL_W       = 2,
  parameter int                          BLOCK_BYTES = 512,
  parameter logic [NUM_DISKS*CAP_W-1:0]  DISK_BLOCKS = '0
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] blocks,
  output logic [DATA_W-1:0] size_bytes
);
  localparam int BB_SHIFT = $clog2(BLOCK_BYTES);

  logic [DATA_W-1:0] cap_tbl [NUM_DISKS];

  for (genvar d = 0; d < NUM_DISKS; d++) begin : g_cap
    assign cap_tbl[d] = DATA_W'(DISK_BLOCKS[d*CAP_W +: CAP_W]);
  end

  always_comb begin
    blocks = '0;
    for (int d = 0; d < NUM_DISKS; d++) begin
      if (sel == SEL_W'(d)) blocks = cap_tbl[d];
    end
  end

  assign size_bytes = blocks << BB_SHIFT;
endmodule

// File: rtl/dkc_regs.sv
module dkc_regs
  import dkc_pkg::*;
#(
  parameter int NUM_DISKS = 3,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  dkc_hit_t          hit,
  input  logic [DATA_W-1:0] blocks,
  output logic [SEL_W-1:0]  disk_q,
  output logic [DATA_W-1:0] block_q,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] phys_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic              start_q,
  output dkc_status_e       status_q
);
  logic wr, rd;
  logic disk_ok, block_ok, count_over;
  logic [DATA_W-1:0] count_next;

  assign wr         = req_valid &&  req_write;
  assign rd         = req_valid && !req_write;
  assign disk_ok    = req_wdata < DATA_W'(NUM_DISKS);
  assign block_ok   = req_wdata < blocks;
  assign count_over = req_wdata >= blocks;
  assign count_next = count_over ? (blocks - DATA_W'(1)) : req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disk_q   <= '0;
      block_q  <= '0;
      count_q  <= '0;
      phys_q   <= '0;
      cmd_q    <= '0;
      start_q  <= 1'b0;
      status_q <= ST_OK;
    end else begin
      start_q <= wr && hit.cmd;
      if (wr) begin
        if (hit.sel) begin
          if (disk_ok) begin
            disk_q   <= req_wdata[SEL_W-1:0];
            status_q <= ST_OK;
          end else begin
            status_q <= ST_BAD_DISK;
          end
        end
        if (hit.blk) begin
          if (block_ok) block_q  <= req_wdata;
          else          status_q <= ST_BAD_BLOCK;
        end
        if (hit.size) begin
          count_q  <= count_next;
          status_q <= ST_OK;
        end
        if (hit.phys) begin
          phys_q   <= req_wdata;
          status_q <= ST_OK;
        end
        if (hit.cmd) cmd_q <= req_wdata;
      end
      if (rd && hit.none) status_q <= ST_BAD_OFFSET;
    end
  end
endmodule

// File: rtl/disk_ctrl_regs.sv
module disk_ctrl_regs
  import dkc_pkg::*;
#(
  parameter int                         NUM_DISKS   = 3,
  parameter int                         ADDR_W      = 8,
  parameter int                         DATA_W      = 32,
  parameter int                         CAP_W       = 32,
  parameter int                         BLOCK_BYTES = 512,
  parameter logic [NUM_DISKS*CAP_W-1:0] DISK_BLOCKS = {32'd64, 32'd20, 32'd8},
  localparam int                        SEL_W       = (NUM_DISKS > 1) ? $clog2(NUM_DISKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [SEL_W-1:0]  disk_sel,
  output logic [DATA_W-1:0] cur_block,
  output logic [DATA_W-1:0] xfer_count,
  output logic [DATA_W-1:0] dma_addr,
  output logic [DATA_W-1:0] cmd_value,
  output logic              cmd_is_write,
  output logic              cmd_start,
  output logic [1:0]        status_code
);
  dkc_hit_t          hit;
  logic [DATA_W-1:0] blocks, size_bytes;
  dkc_status_e       status_q;
  logic [DATA_W-1:0] rd_mux;

  dkc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .hit  (hit)
  );

  dkc_capacity #(
    .NUM_DISKS   (NUM_DISKS),
    .CAP_W       (CAP_W),
    .DATA_W      (DATA_W),
    .SEL_W       (SEL_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .DISK_BLOCKS (DISK_BLOCKS)
  ) u_cap (
    .sel        (disk_sel),
    .blocks     (blocks),
    .size_bytes (size_bytes)
  );

  dkc_regs #(
    .NUM_DISKS (NUM_DISKS),
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .hit       (hit),
    .blocks    (blocks),
    .disk_q    (disk_sel),
    .block_q   (cur_block),
    .count_q   (xfer_count),
    .phys_q    (dma_addr),
    .cmd_q     (cmd_value),
    .start_q   (cmd_start),
    .status_q  (status_q)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit.sel:  rd_mux = DATA_W'(disk_sel);
      hit.blk:  rd_mux = cur_block;
      hit.size: rd_mux = size_bytes;
      hit.phys: rd_mux = dma_addr;
      hit.cmd:  rd_mux = cmd_value;
      hit.stat: rd_mux = DATA_W'(status_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  assign status_code  = status_q;
  assign cmd_is_write = |cmd_value;
endmodule

// File: rtl/disk_ctrl_regs_chk.sv
module disk_ctrl_regs_chk #(
  parameter int                         NUM_DISKS   = 3,
  parameter int                         ADDR_W      = 8,
  parameter int                         DATA_W      = 32,
  parameter int                         CAP_W       = 32,
  parameter logic [NUM_DISKS*CAP_W-1:0] DISK_BLOCKS = '0,
  parameter int                         SEL_W       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [SEL_W-1:0]  disk_sel,
  input logic [DATA_W-1:0] xfer_count,
  input logic              cmd_start,
  input logic [1:0]        status_code
);
  localparam int OFF_W = ADDR_W - 3;

  function automatic logic [DATA_W-1:0] max_cap();
    logic [DATA_W-1:0] m = '0;
    for (int d = 0; d < NUM_DISKS; d++)
      if (DATA_W'(DISK_BLOCKS[d*CAP_W +: CAP_W]) > m) m = DATA_W'(DISK_BLOCKS[d*CAP_W +: CAP_W]);
    return m;
  endfunction

  logic [OFF_W-1:0] slot;
  assign slot = req_addr[ADDR_W-1:3];

  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  p_disk_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    DATA_W'(disk_sel) < DATA_W'(NUM_DISKS));

  p_disk_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && slot == OFF_W'(0) && req_wdata >= DATA_W'(NUM_DISKS))
      |=> (status_code == 2'd1) && $stable(disk_sel));

  p_count_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_count < max_cap());

  p_start_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(req_valid && req_write && slot == OFF_W'(4)));

  p_bad_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && slot > OFF_W'(5))
      |=> (status_code == 2'd3) && (rsp_rdata == '0) && rsp_valid);

  p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && slot <= OFF_W'(5)) |=> $stable(status_code));
endmodule

bind disk_ctrl_regs disk_ctrl_regs_chk #(
  .NUM_DISKS   (NUM_DISKS),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CAP_W       (CAP_W),
  .DISK_BLOCKS (DISK_BLOCKS),
  .SEL_W       (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .disk_sel    (disk_sel),
  .xfer_count  (xfer_count),
  .cmd_start   (cmd_start),
  .status_code (status_code)
);

// File: tb/disk_ctrl_regs_bench.sv
module disk_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  disk_sel;
  logic [31:0] cur_block, xfer_count, dma_addr, cmd_value;
  logic        cmd_is_write, cmd_start;
  logic [1:0]  status_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  disk_ctrl_regs u_disk_ctrl_regs (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .disk_sel, .cur_block, .xfer_count,
    .dma_addr, .cmd_value, .cmd_is_write, .cmd_start, .status_code
  );

  // {is_write, addr, wdata, expected rdata, expected status}
  localparam int NV = 26;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 8'h28, 32'd0,          32'd0,          2'd0}, // R2 status read
    {1'b0, 8'h10, 32'd0,          32'd4096,       2'd0}, // R7 disk0
    {1'b1, 8'h00, 32'd2,          32'd0,          2'd0}, // R3
    {1'b0, 8'h10, 32'd0,          32'd32768,      2'd0}, // R7 disk2
    {1'b0, 8'h00, 32'd0,          32'd2,          2'd0}, // R2
    {1'b1, 8'h08, 32'd63,         32'd0,          2'd0}, // R4 last valid
    {1'b0, 8'h08, 32'd0,          32'd63,         2'd0}, // R2
    {1'b1, 8'h08, 32'd64,         32'd0,          2'd2}, // R4 reject
    {1'b0, 8'h08, 32'd0,          32'd63,         2'd2}, // R4 kept, R10
    {1'b1, 8'h00, 32'd3,          32'd0,          2'd1}, // R3 reject
    {1'b0, 8'h00, 32'd0,          32'd2,          2'd1}, // R3 kept
    {1'b1, 8'h10, 32'd100,        32'd0,          2'd0}, // R5
    {1'b1, 8'h18, 32'hDEAD0000,   32'd0,          2'd0}, // R6
    {1'b0, 8'h18, 32'd0,          32'hDEAD0000,   2'd0}, // R6
    {1'b0, 8'h1D, 32'd0,          32'hDEAD0000,   2'd0}, // R2 low bits
    {1'b0, 8'h30, 32'd0,          32'd0,          2'd3}, // R9
    {1'b0, 8'h28, 32'd0,          32'd3,          2'd3}, // R9 status
    {1'b1, 8'h38, 32'd5,          32'd0,          2'd3}, // R9 ignored
    {1'b1, 8'h28, 32'd0,          32'd0,          2'd3}, // R9 status wr
    {1'b1, 8'h00, 32'd1,          32'd0,          2'd0}, // R3
    {1'b0, 8'h10, 32'd0,          32'd10240,      2'd0}, // R7 disk1
    {1'b1, 8'h08, 32'd20,         32'd0,          2'd2}, // R4 boundary
    {1'b1, 8'h08, 32'd19,         32'd0,          2'd2}, // R4 status kept
    {1'b0, 8'h08, 32'd0,          32'd19,         2'd2}, // R4
    {1'b1, 8'h10, 32'd20,         32'd0,          2'd0}, // R5 boundary
    {1'b0, 8'hF8, 32'd0,          32'd0,          2'd3}  // R9 top slot
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_reset();
    check("R1 disk_sel",   32'(disk_sel), 32'd0);
    check("R1 cur_block",  cur_block, 32'd0);
    check("R1 xfer_count", xfer_count, 32'd0);
    check("R1 dma_addr",   dma_addr, 32'd0);
    check("R1 cmd_value",  cmd_value, 32'd0);
    check("R1 cmd_start",  32'(cmd_start), 32'd0);
    check("R1 rsp_valid",  32'(rsp_valid), 32'd0);
    check("R1 status",     32'(status_code), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VEC[i];
      op(v[74], v[73:66], v[65:34]);
      if (v[74]) begin
        check("R2 no rsp on write", 32'(rsp_valid), 32'd0);
      end else begin
        check("R2 rsp_valid", 32'(rsp_valid), 32'd1);
        check("R2/R7/R9 rdata", rsp_rdata, v[33:2]);
      end
      check("R3/R4/R9 status", 32'(status_code), 32'(v[1:0]));
    end

    check("R3 disk_sel", 32'(disk_sel), 32'd1);
    check("R4 cur_block", cur_block, 32'd19);
    check("R5 clamp at count", xfer_count, 32'd19);
    check("R6 dma_addr", dma_addr, 32'hDEAD0000);
    op(1'b1, 8'h10, 32'd5);
    check("R5 in range", xfer_count, 32'd5);
    op(1'b1, 8'h10, 32'd1000);
    check("R5 clamp over", xfer_count, 32'd19);

    op(1'b1, 8'h20, 32'd7);
    check("R8 start", 32'(cmd_start), 32'd1);
    check("R8 value", cmd_value, 32'd7);
    check("R8 is_write", 32'(cmd_is_write), 32'd1);
    check("R8 status kept", 32'(status_code), 32'd0);
    @(negedge clk);
    check("R8 single pulse", 32'(cmd_start), 32'd0);
    op(1'b1, 8'h20, 32'd0);
    check("R8 start again", 32'(cmd_start), 32'd1);
    check("R8 read cmd", 32'(cmd_is_write), 32'd0);
    op(1'b0, 8'h20, 32'd0);
    check("R2 cmd readback", rsp_rdata, 32'd0);

    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h18;
    @(posedge clk); @(negedge clk);
    check("R2 b2b first valid", 32'(rsp_valid), 32'd1);
    check("R2 b2b first data", rsp_rdata, 32'hDEAD0000);
    req_addr = 8'h00;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b second valid", 32'(rsp_valid), 32'd1);
    check("R2 b2b second data", rsp_rdata, 32'd1);
    @(negedge clk);
    check("R2 rsp ends", 32'(rsp_valid), 32'd0);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    op(1'b0, 8'h10, 32'd0);
    check("R7 after reset", rsp_rdata, 32'd4096);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule